// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This peripheral guards a system against software that stops running. A free-running base tick of one microsecond enters a programmable divider. Each divided tick lowers a 16-bit countdown. Software keeps the countdown away from zero by writing a restart bit at regular intervals. If the countdown runs out while the timer is armed, the block raises a single-cycle reset request toward the system reset controller. It also latches a cause flag that the reset it just requested does not clear.

Software reaches the block through a plain 32-bit register port. That port has single-cycle write and read strobes and a word address, where byte offset = word address × 4. Every access is taken in the cycle it is presented, with no back-pressure. A read returns its data on `rdata` after the rising edge that samples `rd_en`. Two reset inputs are provided. `por_n` clears everything. `rst_n` is the system reset the watchdog itself triggers, and it clears everything except the cause flag. Both resets are synchronous and active low.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, every register reads zero, the timer is disarmed and `rst_req` is low.
- R2: Control sits at byte offset 0x20. Bits [31:16] hold the divisor and bit 7 is the arm bit; all other bits read 0. The timeout count sits at 0x24 and uses bits [15:0] only.
- R3: While armed, the countdown drops by one for every D base ticks, where D is the divisor. A divisor of 0 behaves as 1.
- R4: When the arm bit changes from 0 to 1, the countdown is loaded from the timeout register before any counting.
- R5: Take the loaded value N. If N ≥ 1, the N-th divided tick raises `rst_req`; if N = 0, the first one does. `rst_req` stays high for exactly one clock cycle. The countdown then holds at zero, with no further request until it is reloaded.
- R6: Writing offset 0x00 with bit 9 set reloads the countdown and restarts the divider phase. A write to 0x00 with bit 9 clear changes nothing.
- R7: When the arm bit is cleared, counting stops at once. The countdown holds its value and no request is raised.
- R8: Bit 1 of the system status register at 0x30 is set by an expiry. It survives `rst_n`, is cleared by writing 1 to bit 1, and is cleared by `por_n`.
- R9: A read of offset 0x00 returns the current countdown in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the cause flag |
| base_tick | input | 1 | One-cycle strobe per microsecond |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench places the expiry on an exact base-tick index. This catches a divider that is off by one, a divisor of zero that stalls the timer, and a kick that reloads the count but leaves the old divider phase in place. Each of those faults moves the request to a different tick, or removes it. A write to the kick offset without the restart bit must leave the countdown untouched; a decoder that reacts to any write there would reload it. After an expiry, further ticks must stay quiet, because a design that keeps decrementing or wraps around would fire a second request. Last, the cause flag is checked across a system reset and a power-on reset. A design that puts the flag on the wrong reset would lose it or keep it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WORD_STAT = 0;   // byte 0x00: countdown read / restart write
  localparam int WORD_CTRL = 8;   // byte 0x20: divisor and arm bit
  localparam int WORD_LOAD = 9;   // byte 0x24: timeout count
  localparam int WORD_SYS  = 12;  // byte 0x30: sticky cause flag
  localparam int BIT_ARM   = 7;
  localparam int BIT_KICK  = 9;
  localparam int BIT_CAUSE = 1;
  localparam int DIV_LSB   = 16;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             restart,
  input  logic             base_tick,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] last;
  logic             wrap;

  assign last = (div == '0) ? '0 : div - 1'b1;
  assign wrap = (phase >= last);
  assign tick = arm && !restart && base_tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)                phase <= '0;
    else if (!arm || restart)  phase <= '0;
    else if (base_tick)        phase <= wrap ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             reload,
  output logic             expire
);
  logic arm_q;
  logic halted;

  assign reload = kick || (arm && !arm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      arm_q  <= 1'b0;
      halted <= 1'b0;
      expire <= 1'b0;
    end else begin
      arm_q  <= arm;
      expire <= 1'b0;
      if (reload) begin
        count  <= load_val;
        halted <= 1'b0;
      end else if (tick && arm && !halted) begin
        if (count <= CNT_W'(1)) begin
          count  <= '0;
          halted <= 1'b1;
          expire <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R5
  AST_NO_REQ_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !expire); // R7
  AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !kick) |=> $stable(count)); // R7
  AST_LOAD_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm) |=> (count == $past(load_val))); // R4
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [31:0]       rdata,
  output logic              arm,
  output logic [DIV_W-1:0]  div,
  output logic [CNT_W-1:0]  load_val,
  output logic              kick
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WORD_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WORD_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(WORD_LOAD);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(WORD_SYS);

  logic        cause;
  logic        cause_clr;
  logic [31:0] rd_mux;

  assign kick      = wr_en && (addr == A_STAT) && wdata[BIT_KICK];
  assign cause_clr = wr_en && (addr == A_SYS) && wdata[BIT_CAUSE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm      <= 1'b0;
      div      <= '0;
      load_val <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) begin
        arm <= wdata[BIT_ARM];
        div <= wdata[DIV_LSB +: DIV_W];
      end
      if (addr == A_LOAD) load_val <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)         cause <= 1'b0;
    else if (expire)    cause <= 1'b1;
    else if (cause_clr) cause <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT: rd_mux[CNT_W-1:0] = count;
      A_CTRL: begin
        rd_mux[DIV_LSB +: DIV_W] = div;
        rd_mux[BIT_ARM]          = arm;
      end
      A_LOAD: rd_mux[CNT_W-1:0] = load_val;
      A_SYS:  rd_mux[BIT_CAUSE] = cause;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_CAUSE_ON_EXPIRE: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> cause); // R8
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rst_req
);
  logic             core_rst_n;
  logic             arm;
  logic             kick;
  logic             reload;
  logic             tick;
  logic             expire;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;

  assign core_rst_n = rst_n && por_n;
  assign rst_req    = expire;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .por_n(por_n), .rst_n(core_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .count(count), .expire(expire), .rdata(rdata),
    .arm(arm), .div(div), .load_val(load_val), .kick(kick)
  );

  wdt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(core_rst_n), .arm(arm), .restart(reload),
    .base_tick(base_tick), .div(div), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .arm(arm), .kick(kick), .tick(tick),
    .load_val(load_val), .count(count), .reload(reload), .expire(expire)
  );
endmodule

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int btc = 0;
  int exp_q[$];
  bit prev_req = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tick_watchdog dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .base_tick(base_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    total++;
    if (rdata !== expv) begin
      bad++;
      $display("FAIL %s: addr=%0d actual=%h expected=%h", tag, a, rdata, expv);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1'b1; btc++;
      @(negedge clk); base_tick = 1'b0;
    end
  endtask

  task automatic expect_req(input int delta);
    exp_q.push_back(btc + delta);
  endtask

  always @(negedge clk) begin
    if (rst_req) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5: unexpected request at tick %0d actual=1 expected=0", btc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != btc) begin
          bad++;
          $display("FAIL R3/R5: request tick actual=%0d expected=%0d", btc, e);
        end
      end
      if (prev_req) begin
        bad++;
        $display("FAIL R5: request width actual=2+ expected=1");
      end
    end
    prev_req = rst_req;
  end

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    // R1 reset state
    rd(4'd0,  32'h0, "R1 count");
    rd(4'd8,  32'h0, "R1 ctrl");
    rd(4'd9,  32'h0, "R1 load");
    rd(4'd12, 32'h0, "R1 cause");
    // R2 register layout
    wr(4'd8, 32'h0003_FF7F);
    rd(4'd8, 32'h0003_0000, "R2 ctrl mask");
    wr(4'd9, 32'h0001_0005);
    rd(4'd9, 32'h0000_0005, "R2 load mask");
    // R4 arm loads countdown
    wr(4'd8, 32'h0003_0080);
    rd(4'd8, 32'h0003_0080, "R2 arm readback");
    rd(4'd0, 32'h0000_0005, "R4 load on arm");
    // R3 divide by 3, R9 countdown readback
    ticks(7);
    rd(4'd0, 32'h0000_0003, "R3 R9 divided count");
    // R6 write without restart bit
    wr(4'd0, 32'h0000_01FF);
    rd(4'd0, 32'h0000_0003, "R6 no-kick write ignored");
    // R6 kick reloads and restarts phase
    wr(4'd0, 32'h0000_0200);
    rd(4'd0, 32'h0000_0005, "R6 kick reload");
    expect_req(15);
    ticks(15);
    rd(4'd0, 32'h0, "R5 count held at zero");
    ticks(10);
    rd(4'd12, 32'h2, "R8 cause set");
    // R8 survives system reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd8, 32'h0, "R1 ctrl after rst_n");
    rd(4'd12, 32'h2, "R8 cause kept over rst_n");
    wr(4'd12, 32'h2);
    rd(4'd12, 32'h0, "R8 write-one clear");
    // R3 divisor zero acts as one
    wr(4'd9, 32'd3);
    wr(4'd8, 32'h0000_0080);
    expect_req(3);
    ticks(5);
    // R5 load zero fires on first divided tick
    wr(4'd8, 32'h0);
    wr(4'd9, 32'd0);
    wr(4'd8, 32'h0000_0080);
    expect_req(1);
    ticks(3);
    // R7 disarm holds count
    wr(4'd8, 32'h0);
    wr(4'd9, 32'd4);
    wr(4'd8, 32'h0002_0080);
    ticks(3);
    rd(4'd0, 32'd3, "R3 divide by 2");
    wr(4'd8, 32'h0002_0000);
    ticks(10);
    rd(4'd0, 32'd3, "R7 count frozen while disarmed");
    wr(4'd8, 32'h0002_0080);
    rd(4'd0, 32'd4, "R4 reload on re-arm");
    expect_req(8);
    ticks(10);
    rd(4'd12, 32'h2, "R8 cause set again");
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(4'd12, 32'h0, "R8 cleared by por_n");
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5: missing requests actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule